// File: doc/BRIEF.md
# Banked RAM and SPI Expander Controller

This block sits beside a small 8-bit CPU that has a 16-bit address bus. It adds two things to that CPU: a 128 KB RAM split into four 32 KB banks, and up to four SPI devices. The CPU sends commands to the block through its address bus, not its data bus. When the control strobe is sampled high, the block captures the current address value as a control word. The SPI clock, the four active-low device selects, the MOSI line and a two-bit bank number are all decoded from that word and held in registers. Control-word bits 1 and 8 to 14 have no function. They change during SPI bit-banging, so the block ignores them.

The lower 32 KB of the CPU address space always reaches physical bank 0. The upper 32 KB reaches whichever bank the control word selected.

The SPI clock bit has a second job: it chooses the source of CPU read data. While the clock bit is low, reads return RAM data. While it is high, reads return MISO data, in one of two formats chosen by a mode input:
- **Legacy format:** each device's MISO line appears on its own data bit.
- **Robust format:** data bit 0 carries the MISO line of the selected device, and every other bit reads zero.

Top module: `xbank_spi_ctl`

## Requirements
- R1: After reset, with no strobe yet, the outputs are SCLK low, all four selects high (4'b1111), MOSI low and bank 1.
- R2: When ctl_we is high at a rising clock edge, the outputs take their values from cpu_addr after that edge: spi_sclk from bit 0, spi_ss_n[3:0] from bits 5:2, ram_bank from bits 7:6 and spi_mosi from bit 15.
- R3: While ctl_we is low, spi_sclk, spi_ss_n, spi_mosi and ram_bank keep their values, whatever cpu_addr does.
- R4: Bits 1 and 8 to 14 of a control word have no effect. Two writes that differ only in those bits leave the same output state.
- R5: When cpu_addr[15] is 0, ram_addr is {2'b00, cpu_addr[14:0]}.
- R6: When cpu_addr[15] is 1, ram_addr is {ram_bank, cpu_addr[14:0]}.
- R7: While spi_sclk is low, rd_data equals ram_rdata.
- R8: In legacy mode (robust_mode=0) with spi_sclk high, rd_data is {4'b0000, miso[3:0]}. Bit i carries device i.
- R9: In robust mode (robust_mode=1) with spi_sclk high, rd_data bit 0 is the miso bit of the lowest-numbered device whose select is low, and bits 7:1 are 0. If no select is low, rd_data is 0.
- R10: Writing the control word 16'h007C gives SCLK low, all selects high, bank 1 and MOSI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-write strobe; when high, the address is captured as the control word |
| cpu_addr | input | 16 | CPU address bus; also carries the control word |
| robust_mode | input | 1 | MISO read format: 0 = legacy, 1 = robust |
| miso | input | 4 | MISO lines from SPI devices 0 to 3 |
| ram_rdata | input | 8 | Read data from the RAM |
| ram_addr | output | 17 | Physical RAM address |
| ram_bank | output | 2 | Selected upper bank |
| spi_sclk | output | 1 | SPI clock; also the read-source select |
| spi_ss_n | output | 4 | Active-low device selects |
| spi_mosi | output | 1 | SPI MOSI line |
| rd_data | output | 8 | Read data returned to the CPU |

## Verification
The assertions assume the following about the inputs:
- ctl_we, cpu_addr, robust_mode, miso and ram_rdata are settled by each rising edge.
- Reset is held long enough that no capture overlaps it.

The stimulus changes every input half a period before the next edge. The read path is combinational, so the checks sample it a quarter period after inputs change, and the register outputs after the edge that captured them. Robust-mode cases deliberately drive MISO high on unselected devices and assert more than one select at once, to exercise the priority rule.

// File: rtl/xbank_spi_ctl.sv
module xbank_spi_ctl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_SS   = 4,
  parameter int BANK_W   = 2,
  parameter logic [15:0] CTRL_RESET = 16'h007C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      robust_mode,
  input  logic [NUM_SS-1:0]         miso,
  input  logic [DATA_W-1:0]         ram_rdata,
  output logic [ADDR_W+BANK_W-2:0]  ram_addr,
  output logic [BANK_W-1:0]         ram_bank,
  output logic                      spi_sclk,
  output logic [NUM_SS-1:0]         spi_ss_n,
  output logic                      spi_mosi,
  output logic [DATA_W-1:0]         rd_data
);

  localparam int SCLK_BIT = 0;
  localparam int SS_LSB   = 2;
  localparam int BANK_LSB = SS_LSB + NUM_SS;
  localparam int MOSI_BIT = ADDR_W - 1;
  localparam int OFS_W    = ADDR_W - 1;

  logic              sclk_q;
  logic [NUM_SS-1:0] ss_q;
  logic [BANK_W-1:0] bank_q;
  logic              mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= CTRL_RESET[SCLK_BIT];
      ss_q   <= CTRL_RESET[SS_LSB +: NUM_SS];
      bank_q <= CTRL_RESET[BANK_LSB +: BANK_W];
      mosi_q <= 1'b0;
    end else if (ctl_we) begin
      sclk_q <= cpu_addr[SCLK_BIT];
      ss_q   <= cpu_addr[SS_LSB +: NUM_SS];
      bank_q <= cpu_addr[BANK_LSB +: BANK_W];
      mosi_q <= cpu_addr[MOSI_BIT];
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_ss_n = ss_q;
  assign spi_mosi = mosi_q;
  assign ram_bank = bank_q;

  wire               high_half = cpu_addr[ADDR_W-1];
  wire [BANK_W-1:0]  phys_bank = high_half ? bank_q : '0;
  assign ram_addr = {phys_bank, cpu_addr[OFS_W-1:0]};

  logic sel_miso;
  always_comb begin
    sel_miso = 1'b0;
    for (int i = NUM_SS - 1; i >= 0; i--)
      if (!ss_q[i]) sel_miso = miso[i];
  end

  wire [DATA_W-1:0] legacy_word = {{(DATA_W-NUM_SS){1'b0}}, miso};
  wire [DATA_W-1:0] robust_word = {{(DATA_W-1){1'b0}}, sel_miso};
  wire [DATA_W-1:0] spi_word    = robust_mode ? robust_word : legacy_word;

  assign rd_data = sclk_q ? spi_word : ram_rdata;

endmodule

// File: rtl/xbank_spi_ctl_chk.sv
module xbank_spi_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [15:0] cpu_addr,
  input logic        robust_mode,
  input logic [3:0]  miso,
  input logic [7:0]  ram_rdata,
  input logic [16:0] ram_addr,
  input logic [1:0]  ram_bank,
  input logic        spi_sclk,
  input logic [3:0]  spi_ss_n,
  input logic        spi_mosi,
  input logic [7:0]  rd_data
);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (spi_sclk == $past(cpu_addr[0]) && spi_ss_n == $past(cpu_addr[5:2]) &&
                ram_bank == $past(cpu_addr[7:6]) && spi_mosi == $past(cpu_addr[15])));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable(spi_sclk) && $stable(spi_ss_n) && $stable(ram_bank) && $stable(spi_mosi)));

  a_r5_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (ram_addr[16:15] == 2'b00 && ram_addr[14:0] == cpu_addr[14:0]));

  a_r6_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> (ram_addr[16:15] == ram_bank && ram_addr[14:0] == cpu_addr[14:0]));

  a_r7_ram_path: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sclk |-> rd_data == ram_rdata);

  a_r8_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !robust_mode) |-> (rd_data[7:4] == 4'b0000 && rd_data[3:0] == miso));

  a_r9_robust_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && robust_mode) |-> rd_data[7:1] == 7'd0);

  a_r9_robust_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && robust_mode && (&spi_ss_n)) |-> rd_data == 8'd0);

  a_r9_robust_single: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && robust_mode && $countones(~spi_ss_n) == 1) |-> rd_data[0] == |(miso & ~spi_ss_n));

endmodule

bind xbank_spi_ctl xbank_spi_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cpu_addr(cpu_addr),
  .robust_mode(robust_mode), .miso(miso), .ram_rdata(ram_rdata),
  .ram_addr(ram_addr), .ram_bank(ram_bank), .spi_sclk(spi_sclk),
  .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .rd_data(rd_data)
);

// File: tb/xbank_spi_ctl_tb.sv
module xbank_spi_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        robust_mode = 1'b0;
  logic [3:0]  miso = 4'h0;
  logic [7:0]  ram_rdata = 8'h00;
  logic [16:0] ram_addr;
  logic [1:0]  ram_bank;
  logic        spi_sclk;
  logic [3:0]  spi_ss_n;
  logic        spi_mosi;
  logic [7:0]  rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbank_spi_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cpu_addr(cpu_addr),
    .robust_mode(robust_mode), .miso(miso), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_bank(ram_bank), .spi_sclk(spi_sclk),
    .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .rd_data(rd_data)
  );

  typedef struct {
    string       tag;
    logic        sclk;
    logic [3:0]  ss_n;
    logic        mosi;
    logic [1:0]  bank;
    logic [16:0] addr;
    logic [7:0]  rd;
  } item_t;

  item_t q[$];
  event  ev_push;
  int    compared = 0;
  int    mismatched = 0;

  logic       m_sclk = 1'b0;
  logic [3:0] m_ss = 4'b1111;
  logic       m_mosi = 1'b0;
  logic [1:0] m_bank = 2'd1;

  initial forever begin
    @(ev_push);
    while (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      compared++;
      if (spi_sclk !== e.sclk || spi_ss_n !== e.ss_n || spi_mosi !== e.mosi ||
          ram_bank !== e.bank || ram_addr !== e.addr || rd_data !== e.rd) begin
        mismatched++;
        $display("FAIL %s: got sclk=%b ss_n=%b mosi=%b bank=%0d addr=%h rd=%h exp sclk=%b ss_n=%b mosi=%b bank=%0d addr=%h rd=%h",
          e.tag, spi_sclk, spi_ss_n, spi_mosi, ram_bank, ram_addr, rd_data,
          e.sclk, e.ss_n, e.mosi, e.bank, e.addr, e.rd);
      end
    end
  end

  task automatic write_ctl(input logic [15:0] w);
    @(negedge clk);
    cpu_addr = w;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    m_sclk = w[0];
    m_ss   = w[5:2];
    m_bank = w[7:6];
    m_mosi = w[15];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_sclk = 1'b0; m_ss = 4'b1111; m_mosi = 1'b0; m_bank = 2'd1;
  endtask

  task automatic check(input string tag);
    item_t e;
    logic  b0;
    #(CLK_PERIOD/4);
    e.tag  = tag;
    e.sclk = m_sclk; e.ss_n = m_ss; e.mosi = m_mosi; e.bank = m_bank;
    e.addr = {cpu_addr[15] ? m_bank : 2'b00, cpu_addr[14:0]};
    if (!m_sclk) e.rd = ram_rdata;
    else if (!robust_mode) e.rd = {4'b0000, miso};
    else begin
      b0 = 1'b0;
      if      (!m_ss[0]) b0 = miso[0];
      else if (!m_ss[1]) b0 = miso[1];
      else if (!m_ss[2]) b0 = miso[2];
      else if (!m_ss[3]) b0 = miso[3];
      e.rd = {7'd0, b0};
    end
    q.push_back(e);
    -> ev_push;
    #1;
  endtask

  task automatic set_inputs(input logic [15:0] a, input logic [3:0] mi, input logic [7:0] rr, input logic rm);
    @(negedge clk);
    cpu_addr = a; miso = mi; ram_rdata = rr; robust_mode = rm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0]  snap_r4;
    logic [16:0] dummy;
    dummy = '0;
    do_reset();
    set_inputs(16'h1234, 4'hF, 8'h5A, 1'b0);
    check("R1 reset state");
    check("R7 RAM data with SCLK low");
    set_inputs(16'h8ABC, 4'h0, 8'hC3, 1'b0);
    check("R6 bank 1 high half after reset");

    write_ctl(16'h80C1);
    set_inputs(16'h0100, 4'b1010, 8'hEE, 1'b0);
    check("R2 capture 0x80C1");
    check("R8 legacy MISO bits");

    set_inputs(16'h7FFE, 4'b0101, 8'h11, 1'b0);
    repeat (3) @(negedge clk);
    check("R3 hold without strobe");
    check("R8 legacy second pattern");

    write_ctl(16'h0058);
    set_inputs(16'h0000, 4'h0, 8'h3C, 1'b0);
    check("R2 capture 0x0058");
    snap_r4 = {spi_sclk, spi_ss_n, spi_mosi, ram_bank};
    write_ctl(16'h7F5A);
    set_inputs(16'h0000, 4'h0, 8'h3C, 1'b0);
    check("R4 ignored bits 1 and 14:8");
    if ({spi_sclk, spi_ss_n, spi_mosi, ram_bank} !== snap_r4) begin
      mismatched++;
      $display("FAIL R4: got state %b exp %b", {spi_sclk, spi_ss_n, spi_mosi, ram_bank}, snap_r4);
    end
    compared++;

    set_inputs(16'h1234, 4'h0, 8'h00, 1'b0);
    check("R5 low half to bank 0");
    set_inputs(16'h7FFF, 4'h0, 8'h00, 1'b0);
    check("R5 top of low half");
    for (int b = 0; b < 4; b++) begin
      write_ctl(16'(b << 6) | 16'h003C);
      set_inputs(16'hF234, 4'h0, 8'h99, 1'b0);
      check($sformatf("R6 high half bank %0d", b));
    end

    write_ctl(16'h0035);
    set_inputs(16'h0000, 4'b1101, 8'hFF, 1'b1);
    check("R9 robust single select, MISO 0");
    set_inputs(16'h0000, 4'b0010, 8'hFF, 1'b1);
    check("R9 robust single select, MISO 1");

    write_ctl(16'h0027);
    set_inputs(16'h0000, 4'b0100, 8'hFF, 1'b1);
    check("R9 robust priority lowest select low");
    set_inputs(16'h0000, 4'b0010, 8'hFF, 1'b1);
    check("R9 robust priority lowest select high");

    write_ctl(16'h003D);
    set_inputs(16'h0000, 4'b1111, 8'hFF, 1'b1);
    check("R9 robust none selected reads zero");
    set_inputs(16'h0000, 4'b1111, 8'hFF, 1'b0);
    check("R8 legacy none selected");

    write_ctl(16'h8000);
    write_ctl(16'h007C);
    set_inputs(16'hC001, 4'hF, 8'h42, 1'b1);
    check("R10 deselect word 0x007C");

    write_ctl(16'h80FF);
    do_reset();
    set_inputs(16'h9000, 4'hF, 8'h24, 1'b0);
    check("R1 reset after activity");

    #(CLK_PERIOD);
    if (dummy !== '0) mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule